// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits on the controller side of an SDRAM command bus. It moves the memory between four conditions: idle, auto refresh, self refresh and power down. It drives the chip-select, row strobe, column strobe, write enable and clock enable pins. Host requests arrive on a valid/ready channel and carry a 2-bit operation code. A separate plain `wake` input brings the memory back from either low-power state. A plain `prech` input reports an all-bank precharge that another agent has just placed on the bus. A plain `banks_idle` input says whether every bank is closed.

Each operation has its own timing rules. After an auto refresh the sequencer holds off the next command for the row cycle time. After self refresh it waits for the memory's internal exit, which takes three rising edges after CKE goes high, and then for a further row cycle time. After power down it allows the two-clock exit delay. It also keeps a precharge gap before power-down entry.

The memory does not refresh itself while powered down. A watchdog therefore ends any power-down stay before the refresh period runs out, and it follows the forced exit with an auto refresh.

Back-pressure rules for the request channel:
- A request is taken on a rising edge where `req_valid` and `req_ready` are both high.
- While `req_ready` is low, a request is not taken and has no effect; the host may keep `req_valid` asserted until it is taken.
- `req_ready` depends combinationally on `prech`.

In every cycle without a command the pins carry a NOP.

Top module: `sdram_pwr_seq`

## Requirements
- R1: After reset the pins show a NOP with CKE high (pin vector {cs_n,ras_n,cas_n,we_n,cke} = 01111) and req_ready is high.
- R2: A taken request with op code 0 (auto refresh) puts 00011 on the pins for the one cycle after the accepting edge. The pins then return to NOP. req_ready is low for exactly TRC cycles from the accepting edge and then high.
- R3: A taken request with op code 1 (self-refresh entry) puts 00010 on the pins for one cycle. The pins then show NOP with CKE low (01110) for as long as `wake` is sampled low.
- R4: In self refresh, `wake` sampled high on an edge raises CKE after that edge. req_ready then stays low for XSR_EDGES+TRC cycles, with NOP on the pins.
- R5: A taken request with op code 2 (power down) drives CKE low from the accepting edge, with NOP on the command pins, but only if `banks_idle` is high. With `banks_idle` low the request is taken and has no effect.
- R6: In power down, `wake` sampled high on an edge raises CKE after that edge. req_ready is then low for TPDX cycles and high after that, with no command issued.
- R7: CKE stays low in power down for at most TREF_LIM cycles. On expiry CKE rises, an auto refresh (00011) appears TPDX cycles later, and req_ready returns TRC cycles after that. If `wake` coincides with expiry, the refresh is still issued.
- R8: req_ready is low in any cycle with `prech` high and for the TRP-1 cycles after the edge that samples it.
- R9: A request presented while req_ready is low is not taken and changes neither the pins nor the state.
- R10: Every cycle without a refresh or self-refresh entry carries a NOP: chip-select low, the three strobes high. A command occupies one cycle only.
- R11: Op code 3 is taken and has no effect: the pins stay at NOP with CKE high and req_ready stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 0 refresh, 1 self refresh, 2 power down, 3 no action |
| wake | input | 1 | Leave self refresh or power down |
| prech | input | 1 | All-bank precharge on the bus this cycle |
| banks_idle | input | 1 | All banks closed |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |

## Verification
The bench builds the block with TRC=5, TRP=2, TPDX=2, XSR_EDGES=3 and a short TREF_LIM of 12. With that short limit, a sweep of the wake delay in power down reaches every case: wake well before the watchdog, wake one cycle before it, wake on the same edge, and wake after the forced exit. The self-refresh hold length is also swept, to show that the exit wait does not depend on how long the memory slept. The precharge gap, busy-time requests, the banks-busy power-down request and the spare op code are each driven against expected pin vectors and ready windows, which the bench works out from the parameters.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;

  typedef enum logic [1:0] {
    OP_REFRESH = 2'd0,
    OP_SELFREF = 2'd1,
    OP_PWRDN   = 2'd2,
    OP_NONE    = 2'd3
  } req_op_e;

  typedef enum logic [1:0] {
    CK_NOP     = 2'd0,
    CK_REFRESH = 2'd1,
    CK_SELFREF = 2'd2
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REF  = 3'd1,
    ST_SR   = 3'd2,
    ST_SRX  = 3'd3,
    ST_PD   = 3'd4,
    ST_PDX  = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t PINS_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

  // Self-refresh entry shares the strobe pattern of refresh; CKE tells them apart.
  function automatic cmd_pins_t encode_cmd(cmd_kind_e k);
    cmd_pins_t p;
    unique case (k)
      CK_REFRESH: p = PINS_REF;
      CK_SELFREF: p = PINS_REF;
      default:    p = PINS_NOP;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdram_pwr_cnt.sv
// Loadable down-counter that parks at zero.
module sdram_pwr_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R8: an expired counter stays expired until reloaded
  assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);

  // R7: a load takes the requested value
  assert_cnt_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(val)));

endmodule

// File: rtl/sdram_pwr_pins.sv
// Registered command-pin driver.
module sdram_pwr_pins
  import sdram_pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cmd_kind_e kind,
  input  logic      cke_d,
  output logic      cs_n,
  output logic      ras_n,
  output logic      cas_n,
  output logic      we_n,
  output logic      cke
);
  cmd_pins_t q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= PINS_NOP;
      cke <= 1'b1;
    end else begin
      q   <= encode_cmd(kind);
      cke <= cke_d;
    end
  end

  assign cs_n  = q.cs_n;
  assign ras_n = q.ras_n;
  assign cas_n = q.cas_n;
  assign we_n  = q.we_n;

  // R10: a command lasts one cycle, then the pins fall back to NOP
  assert_cmd_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !q.ras_n |=> (q.ras_n && q.cas_n && q.we_n && !q.cs_n));

endmodule

// File: rtl/sdram_pwr_seq.sv
module sdram_pwr_seq
  import sdram_pwr_pkg::*;
#(
  parameter int TRC       = 5,
  parameter int TRP       = 2,
  parameter int TPDX      = 2,
  parameter int XSR_EDGES = 3,
  parameter int TREF_LIM  = 1560
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_op,
  input  logic       wake,
  input  logic       prech,
  input  logic       banks_idle,
  output logic       cs_n,
  output logic       ras_n,
  output logic       cas_n,
  output logic       we_n,
  output logic       cke
);
  localparam int SRX_CYC = XSR_EDGES + TRC;
  localparam int TMR_MAX = (SRX_CYC > TPDX) ? SRX_CYC : TPDX;
  localparam int TW      = $clog2(TMR_MAX + 1);
  localparam int WW      = $clog2(TREF_LIM + 1);
  localparam int RW      = (TRP > 1) ? $clog2(TRP) : 1;

  seq_state_e state, nxt_state;
  logic       force_ref, force_d;
  cmd_kind_e  kind;
  logic       cke_d;
  logic       tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic       wd_load, wd_zero;
  logic       rp_zero;
  logic       take;
  req_op_e    op;

  assign op        = req_op_e'(req_op);
  assign req_ready = (state == ST_IDLE) && rp_zero && !prech;
  assign take      = req_valid && req_ready;

  sdram_pwr_cnt #(.W(TW)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  sdram_pwr_cnt #(.W(WW)) u_wdog (
    .clk(clk), .rst_n(rst_n), .load(wd_load), .val(WW'(TREF_LIM - 1)), .zero(wd_zero)
  );

  generate
    if (TRP > 1) begin : g_rp
      sdram_pwr_cnt #(.W(RW)) u_rp (
        .clk(clk), .rst_n(rst_n), .load(prech), .val(RW'(TRP - 1)), .zero(rp_zero)
      );
    end else begin : g_no_rp
      assign rp_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    nxt_state = state;
    kind      = CK_NOP;
    cke_d     = cke;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    wd_load   = 1'b0;
    force_d   = force_ref;
    unique case (state)
      ST_IDLE: begin
        if (take) begin
          unique case (op)
            OP_REFRESH: begin
              kind      = CK_REFRESH;
              nxt_state = ST_REF;
              tmr_load  = 1'b1;
              tmr_val   = TW'(TRC - 1);
            end
            OP_SELFREF: begin
              kind      = CK_SELFREF;
              cke_d     = 1'b0;
              nxt_state = ST_SR;
            end
            OP_PWRDN: begin
              if (banks_idle) begin
                cke_d     = 1'b0;
                nxt_state = ST_PD;
                wd_load   = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      ST_REF: begin
        if (tmr_zero) nxt_state = ST_IDLE;
      end
      ST_SR: begin
        cke_d = 1'b0;
        if (wake) begin
          cke_d     = 1'b1;
          nxt_state = ST_SRX;
          tmr_load  = 1'b1;
          tmr_val   = TW'(SRX_CYC - 1);
        end
      end
      ST_SRX: begin
        if (tmr_zero) nxt_state = ST_IDLE;
      end
      ST_PD: begin
        cke_d = 1'b0;
        if (wake || wd_zero) begin
          cke_d     = 1'b1;
          force_d   = wd_zero;
          nxt_state = ST_PDX;
          tmr_load  = 1'b1;
          tmr_val   = TW'(TPDX - 1);
        end
      end
      ST_PDX: begin
        if (tmr_zero) begin
          if (force_ref) begin
            kind      = CK_REFRESH;
            nxt_state = ST_REF;
            tmr_load  = 1'b1;
            tmr_val   = TW'(TRC - 1);
            force_d   = 1'b0;
          end else begin
            nxt_state = ST_IDLE;
          end
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      force_ref <= 1'b0;
    end else begin
      state     <= nxt_state;
      force_ref <= force_d;
    end
  end

  sdram_pwr_pins u_pins (
    .clk(clk), .rst_n(rst_n), .kind(kind), .cke_d(cke_d),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke)
  );

  // R3: CKE is held low throughout self refresh
  assert_sr_cke_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SR) |-> !cke);

  // R4: during the self-refresh exit wait CKE is high and no request is taken
  assert_srx_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SRX) |-> (cke && !req_ready));

  // R5: power down is only entered from idle with all banks closed
  assert_pd_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PD && $past(state) == ST_IDLE) |-> ($past(banks_idle) && !cke));

  // R7: watchdog expiry ends power down on the next edge
  assert_wd_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PD && wd_zero) |=> (cke && state == ST_PDX));

  // R9: a request while busy leaves the idle state untouched
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && req_valid && !req_ready) |=> (state == ST_IDLE && cke));

endmodule

// File: tb/test_sdram_pwr_seq.sv
`timescale 1ns/1ps
module test_sdram_pwr_seq;
  localparam int TRC = 5, TRP = 2, TPDX = 2, XSR = 3, LIM = 12;
  localparam logic [4:0] P_NOP_H = 5'b01111, P_NOP_L = 5'b01110,
                         P_REF = 5'b00011,  P_SRE = 5'b00010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, wake = 1'b0, prech = 1'b0, banks_idle = 1'b1;
  logic [1:0] req_op = 2'd0;
  logic req_ready, cs_n, ras_n, cas_n, we_n, cke;
  wire  [4:0] pins = {cs_n, ras_n, cas_n, we_n, cke};
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  sdram_pwr_seq #(.TRC(TRC), .TRP(TRP), .TPDX(TPDX), .XSR_EDGES(XSR), .TREF_LIM(LIM))
  i_sdram_pwr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .wake(wake), .prech(prech), .banks_idle(banks_idle),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic report();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // Present a request while ready is high; return just after the accepting edge.
  task automatic take(input logic [1:0] op, input string tag);
    req_op = op; req_valid = 1'b1; #1;
    chk({tag, " ready before take"}, req_ready, 1);
    cyc(); req_valid = 1'b0; #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1; #1;
    chk("R1 pins after reset", pins, P_NOP_H);
    chk("R1 ready after reset", req_ready, 1);

    // R2 refresh window, with R9 busy requests presented throughout
    take(2'd0, "R2");
    for (int s = 0; s <= TRC; s++) begin
      chk("R2 refresh pins", pins, (s == 0) ? P_REF : P_NOP_H);
      chk("R2 ready window", req_ready, (s == TRC) ? 1 : 0);
      if (s < TRC) begin req_valid = 1'b1; req_op = 2'd1; end
      else req_valid = 1'b0;
      cyc(); #1;
    end
    chk("R9 busy request left no trace", pins, P_NOP_H);
    chk("R9 busy request ready", req_ready, 1);

    // R3/R4 self refresh with swept sleep length
    for (int h = 0; h <= 4; h++) begin
      take(2'd1, "R3");
      chk("R3 entry pins", pins, P_SRE);
      chk("R3 entry ready", req_ready, 0);
      for (int k = 0; k < h; k++) begin
        cyc(); #1;
        chk("R3 held pins", pins, P_NOP_L);
      end
      wake = 1'b1; cyc(); wake = 1'b0; #1;
      for (int s = 0; s <= XSR + TRC; s++) begin
        chk("R4 exit pins", pins, P_NOP_H);
        chk("R4 exit ready", req_ready, (s == XSR + TRC) ? 1 : 0);
        if (s < XSR + TRC) begin cyc(); #1; end
      end
    end

    // R6/R7 power down, wake pulse at sample d
    for (int d = 0; d <= 13; d++) begin
      int sx, fin;
      bit forced;
      forced = (d + 1 >= LIM);
      sx  = forced ? LIM : d + 1;
      fin = sx + TPDX + (forced ? TRC : 0);
      take(2'd2, "R5");
      for (int s = 0; s <= fin; s++) begin
        logic [4:0] ep;
        bit er;
        ep = (s < sx) ? P_NOP_L : ((forced && s == sx + TPDX) ? P_REF : P_NOP_H);
        er = (s == fin);
        if (s == 0) chk("R5 entry pins", pins, P_NOP_L);
        else if (forced) chk("R7 forced exit pins", pins, ep);
        else chk("R6 wake exit pins", pins, ep);
        chk(forced ? "R7 ready" : "R6 ready", req_ready, er);
        wake = (s == d);
        cyc(); #1;
      end
      wake = 1'b0;
    end

    // R8 precharge gap, request blocked in the prech cycle
    req_valid = 1'b1; req_op = 2'd2; prech = 1'b1; #1;
    chk("R8 ready with prech", req_ready, 0);
    cyc(); prech = 1'b0; #1;
    chk("R8 pins not taken", pins, P_NOP_H);
    for (int s = 0; s < TRP - 1; s++) begin
      chk("R8 ready in gap", req_ready, 0);
      cyc(); #1;
      chk("R8 gap pins", pins, P_NOP_H);
    end
    chk("R8 ready after gap", req_ready, 1);
    cyc(); req_valid = 1'b0; #1;
    chk("R8 power down after gap", pins, P_NOP_L);
    wake = 1'b1; cyc(); wake = 1'b0; #1;
    for (int s = 0; s < TPDX; s++) begin cyc(); #1; end
    chk("R6 back to idle", req_ready, 1);

    // R5 power down refused with banks busy
    banks_idle = 1'b0;
    take(2'd2, "R5");
    chk("R5 busy banks pins", pins, P_NOP_H);
    chk("R5 busy banks ready", req_ready, 1);
    cyc(); #1;
    chk("R5 busy banks stays up", pins, P_NOP_H);
    banks_idle = 1'b1;

    // R11 spare op code
    take(2'd3, "R11");
    chk("R11 pins", pins, P_NOP_H);
    chk("R11 ready", req_ready, 1);

    // R10 wake outside low-power states does nothing
    wake = 1'b1; cyc(); wake = 1'b0; #1;
    chk("R10 idle wake pins", pins, P_NOP_H);
    chk("R10 idle wake ready", req_ready, 1);

    report();
  end
endmodule